// File: doc/BRIEF.md
# Device-Aware Single-Error-Correcting Word Codec (12,8)

The codec protects an 8-bit data value stored as a 12-bit word spread over three memory devices, each 4 bits wide. A combinational encoder turns the data into a 12-bit codeword with 4 check bits. A registered decoder takes a stored word together with a strobe. It computes a 4-bit syndrome, repairs any single flipped bit, and flags as uncorrectable any word in which two bits inside the same device have flipped. Such a word is never miscorrected.

The parity-check matrix is chosen so that the columns belonging to one device form a coset of a two-dimensional subspace. The XOR of any two columns in one device then always lands on one of the three syndromes that no column uses: 3, 12 and 15. The decoder is a small state machine. It has the states IDLE (no result), CLEAN (word had no error), FIXED (one bit repaired) and FAULT (uncorrectable). The state is entered one cycle after a strobe and drives the flags. From any state, a strobe moves the machine to CLEAN, FIXED or FAULT according to the syndrome class, and a cycle without a strobe returns it to IDLE.

Top module: `chip_sec_codec`

## Requirements
- R1: Bit i of the word has a parity-check column, with syndrome bit 0 as the LSB. For i = 0..11 the columns are 1, 2, 13, 14, 4, 7, 8, 11, 5, 6, 9, 10. The syndrome is the XOR of the columns of all set word bits. Devices are bits 0-3, 4-7 and 8-11.
- R2: The encoder output carries data bits 0..7 at word positions 2, 3, 5, 7, 8, 9, 10, 11 in ascending order. It carries check bits at positions 0, 1, 4, 6, and every output word has a zero syndrome.
- R3: A word with a zero syndrome gives, one cycle after the strobe, dec_data_o equal to its data field, with dec_fixed_o and dec_fault_o both low.
- R4: A word whose syndrome equals column i gives bit i flipped back: dec_data_o holds the data field of the repaired word, dec_fixed_o=1 and dec_fault_o=0.
- R5: Any other syndrome, which includes every pair of flipped bits inside one device, gives dec_fault_o=1 and dec_fixed_o=0, with dec_data_o equal to the unmodified data field of the input word.
- R6: dec_ready_o is high exactly in the cycle after a strobe cycle. Both flags are low whenever dec_ready_o is low, and dec_data_o holds its value across cycles without a strobe.
- R7: After reset, dec_ready_o, dec_fixed_o and dec_fault_o are 0 and dec_data_o is 0.
- R8: dec_fixed_o and dec_fault_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_data_i | input | 8 | Data to encode |
| enc_word_o | output | 12 | Codeword for enc_data_i (combinational) |
| dec_strobe_i | input | 1 | dec_word_i is valid this cycle |
| dec_word_i | input | 12 | Stored word to check |
| dec_data_o | output | 8 | Repaired or raw data field |
| dec_ready_o | output | 1 | Decode result valid |
| dec_fixed_o | output | 1 | A single bit was repaired |
| dec_fault_o | output | 1 | Uncorrectable word detected |

## Verification
The bench builds the codec with its default geometry of three 4-bit devices and 8 data bits. At that size an exhaustive sweep is affordable. All 256 data values are encoded and checked against a syndrome computed from the column table in R1. Each codeword is then decoded clean, with each of its 12 single-bit flips, and with each of the 18 same-device bit pairs. This reaches all three unused syndromes and repairs at every bit position, including the check bits. Strobe gaps are inserted to observe the return to IDLE and the holding of the data output.

// File: rtl/chip_sec_pkg.sv
package chip_sec_pkg;

    localparam int DEV_W  = 4;
    localparam int N_DEV  = 3;
    localparam int WORD_W = DEV_W * N_DEV;
    localparam int CHK_W  = 4;
    localparam int DATA_W = WORD_W - CHK_W;

    typedef logic [CHK_W-1:0]  syn_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef enum logic [1:0] {
        CLS_CLEAN  = 2'd0,
        CLS_SINGLE = 2'd1,
        CLS_MULTI  = 2'd2
    } cls_t;

    // Column of word bit i: an invertible linear map applied to (i + DEV_W).
    // The values i+DEV_W run over the three non-trivial cosets of span{1,2},
    // one coset per device, so same-device pair sums fall outside the column set.
    function automatic syn_t h_col(input int i);
        logic [3:0] v;
        v = 4'(i + DEV_W);
        return {v[1], v[3] ^ v[1], v[0], v[2] ^ v[0]};
    endfunction

    function automatic bit is_chk(input int i);
        return $countones(h_col(i)) == 1;
    endfunction

    function automatic int chk_pos(input int k);
        int r;
        r = 0;
        for (int i = 0; i < WORD_W; i++)
            if (h_col(i) == syn_t'(1 << k)) r = i;
        return r;
    endfunction

    function automatic int data_pos(input int j);
        int r;
        int n;
        r = 0;
        n = 0;
        for (int i = 0; i < WORD_W; i++) begin
            if (!is_chk(i)) begin
                if (n == j) r = i;
                n++;
            end
        end
        return r;
    endfunction

    function automatic data_t data_field(input word_t w);
        data_t d;
        for (int j = 0; j < DATA_W; j++) d[j] = w[data_pos(j)];
        return d;
    endfunction

endpackage

// File: rtl/chip_sec_enc.sv
module chip_sec_enc
    import chip_sec_pkg::*;
(
    input  data_t data_i,
    output word_t word_o
);

    always_comb begin
        word_t w;
        w = '0;
        for (int j = 0; j < DATA_W; j++) w[data_pos(j)] = data_i[j];
        for (int k = 0; k < CHK_W; k++) begin
            logic p;
            p = 1'b0;
            for (int j = 0; j < DATA_W; j++)
                if (h_col(data_pos(j))[k]) p = p ^ data_i[j];
            w[chk_pos(k)] = p;
        end
        word_o = w;
    end

endmodule

// File: rtl/chip_sec_syn.sv
module chip_sec_syn
    import chip_sec_pkg::*;
(
    input  word_t word_i,
    output word_t flip_o,
    output cls_t  cls_o
);

    syn_t syn;

    always_comb begin
        syn = '0;
        for (int i = 0; i < WORD_W; i++)
            if (word_i[i]) syn = syn ^ h_col(i);
    end

    for (genvar g = 0; g < WORD_W; g++) begin : g_loc
        assign flip_o[g] = (syn == h_col(g));
    end

    always_comb begin
        if (syn == '0)   cls_o = CLS_CLEAN;
        else if (|flip_o) cls_o = CLS_SINGLE;
        else             cls_o = CLS_MULTI;
    end

endmodule

// File: rtl/chip_sec_dec.sv
module chip_sec_dec
    import chip_sec_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  strobe_i,
    input  word_t word_i,
    input  word_t flip_i,
    input  cls_t  cls_i,
    output data_t data_o,
    output logic  ready_o,
    output logic  fixed_o,
    output logic  fault_o
);

    typedef enum logic [1:0] {
        DS_IDLE  = 2'd0,
        DS_CLEAN = 2'd1,
        DS_FIXED = 2'd2,
        DS_FAULT = 2'd3
    } dstate_t;

    dstate_t state_q, state_d;
    data_t   data_q;

    function automatic dstate_t on_strobe(input cls_t c);
        dstate_t s;
        unique case (c)
            CLS_CLEAN:  s = DS_CLEAN;
            CLS_SINGLE: s = DS_FIXED;
            default:    s = DS_FAULT;
        endcase
        return s;
    endfunction

    always_comb begin
        unique case (state_q)
            DS_IDLE:  state_d = strobe_i ? on_strobe(cls_i) : DS_IDLE;
            DS_CLEAN: state_d = strobe_i ? on_strobe(cls_i) : DS_IDLE;
            DS_FIXED: state_d = strobe_i ? on_strobe(cls_i) : DS_IDLE;
            DS_FAULT: state_d = strobe_i ? on_strobe(cls_i) : DS_IDLE;
            default:  state_d = DS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            data_q <= '0;
        else if (strobe_i)
            data_q <= (cls_i == CLS_SINGLE) ? data_field(word_i ^ flip_i)
                                            : data_field(word_i);
    end

    always_comb begin
        ready_o = 1'b0;
        fixed_o = 1'b0;
        fault_o = 1'b0;
        unique case (state_q)
            DS_IDLE:  ;
            DS_CLEAN: ready_o = 1'b1;
            DS_FIXED: begin ready_o = 1'b1; fixed_o = 1'b1; end
            DS_FAULT: begin ready_o = 1'b1; fault_o = 1'b1; end
            default:  ;
        endcase
    end

    assign data_o = data_q;

endmodule

// File: rtl/chip_sec_codec.sv
module chip_sec_codec
    import chip_sec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [WORD_W-1:0] enc_word_o,
    input  logic              dec_strobe_i,
    input  logic [WORD_W-1:0] dec_word_i,
    output logic [DATA_W-1:0] dec_data_o,
    output logic              dec_ready_o,
    output logic              dec_fixed_o,
    output logic              dec_fault_o
);

    word_t flip;
    cls_t  cls;

    chip_sec_enc u_enc (
        .data_i (enc_data_i),
        .word_o (enc_word_o)
    );

    chip_sec_syn u_syn (
        .word_i (dec_word_i),
        .flip_o (flip),
        .cls_o  (cls)
    );

    chip_sec_dec u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (dec_strobe_i),
        .word_i   (dec_word_i),
        .flip_i   (flip),
        .cls_i    (cls),
        .data_o   (dec_data_o),
        .ready_o  (dec_ready_o),
        .fixed_o  (dec_fixed_o),
        .fault_o  (dec_fault_o)
    );

endmodule

// File: rtl/chip_sec_chk.sv
module chip_sec_chk
    import chip_sec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] enc_data_i,
    input logic [WORD_W-1:0] enc_word_o,
    input logic              dec_strobe_i,
    input logic [WORD_W-1:0] dec_word_i,
    input logic [DATA_W-1:0] dec_data_o,
    input logic              dec_ready_o,
    input logic              dec_fixed_o,
    input logic              dec_fault_o
);

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_fixed_o && dec_fault_o)); // R8

    AST_READY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_strobe_i |=> dec_ready_o); // R6

    AST_IDLE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_strobe_i |=> !dec_ready_o); // R6

    AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_ready_o |-> (!dec_fixed_o && !dec_fault_o)); // R6

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_strobe_i |=> $stable(dec_data_o)); // R6

    AST_ROUNDTRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_strobe_i && dec_word_i == enc_word_o) |=>
        (!dec_fixed_o && !dec_fault_o && dec_data_o == $past(enc_data_i))); // R3

endmodule

bind chip_sec_codec chip_sec_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enc_data_i   (enc_data_i),
    .enc_word_o   (enc_word_o),
    .dec_strobe_i (dec_strobe_i),
    .dec_word_i   (dec_word_i),
    .dec_data_o   (dec_data_o),
    .dec_ready_o  (dec_ready_o),
    .dec_fixed_o  (dec_fixed_o),
    .dec_fault_o  (dec_fault_o)
);

// File: tb/sim_chip_sec_codec.sv
`timescale 1ns/1ps
module sim_chip_sec_codec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  enc_data_i = '0;
    logic [11:0] enc_word_o;
    logic        dec_strobe_i = 1'b0;
    logic [11:0] dec_word_i = '0;
    logic [7:0]  dec_data_o;
    logic        dec_ready_o;
    logic        dec_fixed_o;
    logic        dec_fault_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [3:0] col [12];
    int         dpos [8];

    always #5 clk = ~clk;

    chip_sec_codec u0 (.*);

    function automatic logic [3:0] syn_of(input logic [11:0] w);
        logic [3:0] s = '0;
        for (int i = 0; i < 12; i++) if (w[i]) s ^= col[i];
        return s;
    endfunction

    function automatic logic [7:0] field_of(input logic [11:0] w);
        logic [7:0] d;
        for (int j = 0; j < 8; j++) d[j] = w[dpos[j]];
        return d;
    endfunction

    // R2 layout: check bit k sits where the column is the unit vector 1<<k
    function automatic logic [11:0] code_of(input logic [7:0] d);
        logic [11:0] w = '0;
        logic [3:0]  s;
        for (int j = 0; j < 8; j++) w[dpos[j]] = d[j];
        s = syn_of(w);
        w[0] = s[0]; w[1] = s[1]; w[4] = s[2]; w[6] = s[3];
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a negedge; result sampled at the following negedge
    task automatic dec_run(input logic [11:0] w, input logic [7:0] ed,
                           input int ecls, input string req);
        dec_strobe_i = 1'b1;
        dec_word_i   = w;
        @(negedge clk);
        chk(dec_ready_o == 1'b1, req, dec_ready_o, 1);
        chk(dec_data_o == ed, req, dec_data_o, ed);
        chk({dec_fault_o, dec_fixed_o} == 2'(ecls), req,
            {dec_fault_o, dec_fixed_o}, ecls);
    endtask

    initial begin
        col[0] = 4'd1;  col[1] = 4'd2;  col[2]  = 4'd13; col[3]  = 4'd14;
        col[4] = 4'd4;  col[5] = 4'd7;  col[6]  = 4'd8;  col[7]  = 4'd11;
        col[8] = 4'd5;  col[9] = 4'd6;  col[10] = 4'd9;  col[11] = 4'd10;
        dpos[0] = 2; dpos[1] = 3; dpos[2] = 5; dpos[3] = 7;
        dpos[4] = 8; dpos[5] = 9; dpos[6] = 10; dpos[7] = 11;

        repeat (3) @(negedge clk);
        // R7 reset state
        chk(dec_ready_o == 0 && dec_fixed_o == 0 && dec_fault_o == 0, "R7 flags",
            {dec_ready_o, dec_fixed_o, dec_fault_o}, 0);
        chk(dec_data_o == 0, "R7 data", dec_data_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dec_ready_o == 0, "R6 no strobe after reset", dec_ready_o, 0);

        for (int d = 0; d < 256; d++) begin
            logic [11:0] cw;
            cw = code_of(8'(d));
            enc_data_i = 8'(d);
            #1;
            chk(enc_word_o == cw, "R2 encoder word", enc_word_o, cw);
            chk(syn_of(enc_word_o) == 0, "R1 zero syndrome", syn_of(enc_word_o), 0);
            #1;
            // R3 clean word
            dec_run(cw, 8'(d), 0, "R3 clean");
            // R4 every single flip
            for (int i = 0; i < 12; i++)
                dec_run(cw ^ (12'd1 << i), 8'(d), 1, "R4 single");
            // R5 every pair inside one device
            for (int dv = 0; dv < 3; dv++)
                for (int a = 0; a < 4; a++)
                    for (int b = a + 1; b < 4; b++) begin
                        logic [11:0] bad;
                        bad = cw ^ (12'd1 << (4*dv + a)) ^ (12'd1 << (4*dv + b));
                        dec_run(bad, field_of(bad), 2, "R5 device pair");
                    end
            if (d % 16 == 5) begin
                logic [7:0] held;
                held = dec_data_o;
                dec_strobe_i = 1'b0;
                dec_word_i   = ~dec_word_i;
                @(negedge clk);
                chk(dec_ready_o == 0 && dec_fixed_o == 0 && dec_fault_o == 0,
                    "R6 idle flags", {dec_ready_o, dec_fixed_o, dec_fault_o}, 0);
                chk(dec_data_o == held, "R6 data hold", dec_data_o, held);
            end
            chk(!(dec_fixed_o && dec_fault_o), "R8 exclusive",
                {dec_fixed_o, dec_fault_o}, 0);
        end

        dec_strobe_i = 1'b0;
        @(negedge clk);
        chk(dec_ready_o == 0, "R6 final idle", dec_ready_o, 0);

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule